// File: doc/BRIEF.md
# Conversion Result Threshold Comparator

This block watches the stream of finished analog-to-digital conversion results and raises a sticky comparison flag when a result meets a software-programmed condition against a 12-bit threshold. Each result arrives with a one-cycle valid strobe, the 12-bit value and the 5-bit number of the channel that produced it.

The condition has two parts. A direction bit chooses between "result at or above the threshold" and "result below the threshold". A scope bit chooses between testing every channel and testing only the channel named in the control register. A master enable turns the whole check off. Software programs the threshold and the control word through a small register port. It reads the flag back from a status word and clears it by writing 0. The interrupt line follows the flag.

Top module: `conv_result_cmp`

## Requirements
- R1: After reset the threshold reads 0, the control word reads 0, and both the flag and the interrupt line are low.
- R2: A write to address 0 stores bits [11:0] as the threshold. A read of address 0 returns the threshold in bits [11:0], with bits [15:12] reading 0.
- R3: A write to address 1 stores the control word: bit 7 is the enable, bits 6:5 are the mode and bits 4:0 are the selected channel. A read of address 1 returns these 8 bits, with the upper bits reading 0.
- R4: With mode bit 0 clear, an enabled and channel-qualified result that is greater than or equal to the threshold sets the flag. A smaller result does not set it.
- R5: With mode bit 0 set, an enabled and channel-qualified result that is strictly less than the threshold sets the flag. A result that is equal or larger does not set it.
- R6: With mode bit 1 clear, a result from any channel qualifies. With mode bit 1 set, only a result whose channel number equals control bits 4:0 qualifies.
- R7: While the enable bit is clear, no result sets the flag, whatever its value or channel.
- R8: Results are evaluated only in a cycle with the valid strobe high. The flag changes on the clock edge that samples the strobe, so it is first seen high in the cycle after the strobe.
- R9: A read of address 2 returns the flag in bit 0. Writing address 2 with bit 0 = 0 clears the flag, and writing bit 0 = 1 has no effect. If a setting result and a clearing write occur in the same cycle, the flag ends up set.
- R10: The interrupt output always equals the flag.
- R11: Once set, the flag stays set through later results that do not meet the condition, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register address: 0 threshold, 1 control, 2 status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| resValid | input | 1 | One-cycle strobe: a conversion result is present |
| resData | input | 12 | Conversion result |
| resChan | input | 5 | Channel number of the result |
| cmpFlag | output | 1 | Sticky comparison flag |
| cmpIrq | output | 1 | Interrupt request, equal to the flag |

## Verification
The assertions assume that the valid strobe, the result and the channel number are driven to clean levels, and that register writes use only the three defined addresses. They also assume that a result and a write can coincide only in the way R9 defines. The bench drives every input on the falling edge and holds it for exactly one rising edge, so each strobe and each write is seen once. The bench sweeps thresholds at the ends and the middle of the range against results at and just around the threshold. It does this for all four modes and for matching and non-matching channels, and adds directed cycles for the simultaneous set-and-clear case and for the disabled case.

// File: rtl/conv_cmp_pkg.sv
package conv_cmp_pkg;
  // Register map (word addresses)
  localparam int ADDR_REF  = 0;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_STAT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic refWr;    // threshold write
    logic flagClr;  // software clear request
    logic evalEn;   // qualified result present this cycle
    logic dirLt;    // 1: test result < threshold, 0: result >= threshold
  } cmpStrobe_t;
endpackage

// File: rtl/conv_cmp_ctrl.sv
module conv_cmp_ctrl
  import conv_cmp_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BUS_W  = 16,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CH_W+2:0]   regWrLow,
  input  logic              resValid,
  input  logic [CH_W-1:0]   resChan,
  output cmpStrobe_t        strobe,
  output logic [BUS_W-1:0]  ctrlView
);
  localparam int CTRL_W = CH_W + 3;

  logic            enReg;
  logic [1:0]      modeReg;
  logic [CH_W-1:0] chanReg;
  logic            ctrlWr;
  logic            chanOk;

  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      modeReg <= 2'b00;
      chanReg <= '0;
    end else if (ctrlWr) begin
      enReg   <= regWrLow[CH_W+2];
      modeReg <= regWrLow[CH_W+1:CH_W];
      chanReg <= regWrLow[CH_W-1:0];
    end
  end

  // Channel filter: scope bit (mode[1]) restricts to one channel
  assign chanOk = !modeReg[1] || (resChan == chanReg);

  always_comb begin
    strobe.refWr   = regWrEn && (regAddr == ADDR_W'(ADDR_REF));
    strobe.flagClr = regWrEn && (regAddr == ADDR_W'(ADDR_STAT)) && !regWrLow[0];
    strobe.evalEn  = resValid && enReg && chanOk;
    strobe.dirLt   = modeReg[0];
  end

  assign ctrlView = BUS_W'({enReg, modeReg, chanReg});

  // R3: control write is reflected in the read view on the next cycle
  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> ctrlView[CTRL_W-1:0] == $past(regWrLow));

  // R7: a strobe while disabled never qualifies
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !ctrlView[CTRL_W-1]) |-> !strobe.evalEn);
endmodule

// File: rtl/conv_cmp_dp.sv
module conv_cmp_dp
  import conv_cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] resData,
  output logic [BUS_W-1:0]  refView,
  output logic              cmpFlag
);
  logic [DATA_W-1:0] refReg;
  logic              condMet;
  logic              hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refReg <= '0;
    else if (strobe.refWr) refReg <= wrData;
  end

  assign condMet = strobe.dirLt ? (resData < refReg) : (resData >= refReg);
  assign hit     = strobe.evalEn && condMet;

  // Set has priority over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cmpFlag <= 1'b0;
    else if (hit)            cmpFlag <= 1'b1;
    else if (strobe.flagClr) cmpFlag <= 1'b0;
  end

  assign refView = BUS_W'(refReg);

  assert_ref_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refWr |=> refView[DATA_W-1:0] == $past(wrData));

  assert_ge_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalEn && !strobe.dirLt && resData >= refView[DATA_W-1:0]) |=> cmpFlag);

  assert_lt_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalEn && strobe.dirLt && resData < refView[DATA_W-1:0]) |=> cmpFlag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagClr && !strobe.evalEn) |=> !cmpFlag);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.evalEn && !strobe.flagClr) |=> $stable(cmpFlag));
endmodule

// File: rtl/conv_result_cmp.sv
module conv_result_cmp
  import conv_cmp_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BUS_W  = 16,
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic [CH_W-1:0]   resChan,
  output logic              cmpFlag,
  output logic              cmpIrq
);
  cmpStrobe_t       strobe;
  logic [BUS_W-1:0] ctrlView;
  logic [BUS_W-1:0] refView;
  logic             unusedWrHi;

  assign unusedWrHi = ^regWrData[BUS_W-1:DATA_W];

  conv_cmp_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrLow (regWrData[CH_W+2:0]),
    .resValid (resValid),
    .resChan  (resChan),
    .strobe   (strobe),
    .ctrlView (ctrlView)
  );

  conv_cmp_dp #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData[DATA_W-1:0]),
    .resData (resData),
    .refView (refView),
    .cmpFlag (cmpFlag)
  );

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_REF))       regRdData = refView;
    else if (regAddr == ADDR_W'(ADDR_CTRL)) regRdData = ctrlView;
    else if (regAddr == ADDR_W'(ADDR_STAT)) regRdData = BUS_W'(cmpFlag);
    else                                    regRdData = '0;
  end

  assign cmpIrq = cmpFlag;

  // R8: the flag rises only after a cycle that carried a result strobe
  assert_rise_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> $past(resValid));
endmodule

// File: tb/conv_result_cmp_bench.sv
module conv_result_cmp_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        resValid = 1'b0;
  logic [11:0] resData = '0;
  logic [4:0]  resChan = '0;
  logic        cmpFlag, cmpIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  conv_result_cmp u_conv_result_cmp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .resValid(resValid),
    .resData(resData), .resChan(resChan), .cmpFlag(cmpFlag), .cmpIrq(cmpIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic sendResult(input logic [11:0] v, input logic [4:0] ch);
    resData = v; resChan = ch; resValid = 1'b1;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] rd;
    logic [11:0] refs [4];
    refs[0] = 12'h000; refs[1] = 12'h001; refs[2] = 12'h800; refs[3] = 12'hFFF;

    repeat (3) @(negedge clk);
    // R1: reset state
    busRead(0, rd); check(rd == 0, "R1 threshold", rd, 0);
    busRead(1, rd); check(rd == 0, "R1 control", rd, 0);
    check(cmpFlag == 0 && cmpIrq == 0, "R1 flag/irq", {cmpFlag, cmpIrq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: threshold width, upper bits read 0
    busWrite(0, 16'hFFFF);
    busRead(0, rd); check(rd == 16'h0FFF, "R2 readback", rd, 16'h0FFF);
    // R3: control readback
    busWrite(1, 16'hFFAB);
    busRead(1, rd); check(rd == 16'h00AB, "R3 readback", rd, 16'h00AB);

    // Sweep: R4 R5 R6 R10 over thresholds, results, modes, channels
    for (int ri = 0; ri < 4; ri++) begin
      busWrite(0, {4'h0, refs[ri]});
      for (int m = 0; m < 4; m++) begin
        busWrite(1, 16'(8'h80 | (m << 5) | 5));
        for (int k = 0; k < 6; k++) begin
          for (int c = 0; c < 2; c++) begin
            logic [11:0] v;
            logic [4:0] ch;
            bit exp;
            case (k)
              0: v = 12'h000;
              1: v = 12'h001;
              2: v = refs[ri] - 12'd1;
              3: v = refs[ri];
              4: v = refs[ri] + 12'd1;
              default: v = 12'hFFF;
            endcase
            ch = (c == 0) ? 5'd5 : 5'd31;
            exp = ((m & 2) ? (ch == 5'd5) : 1'b1) &&
                  ((m & 1) ? (v < refs[ri]) : (v >= refs[ri]));
            busWrite(2, 16'h0000);
            sendResult(v, ch);
            check(cmpFlag == exp, (m & 2) ? "R6 R4/R5 filtered" : "R4/R5 all-channel",
                  cmpFlag, exp);
            check(cmpIrq == cmpFlag, "R10 irq", cmpIrq, cmpFlag);
          end
        end
      end
    end

    // R7: disabled, a result that would match does not set
    busWrite(0, 16'h0010);
    busWrite(1, 16'h0000); // enable 0, >= mode, all channels
    busWrite(2, 16'h0000);
    sendResult(12'hFFF, 5'd3);
    check(cmpFlag == 0, "R7 disabled", cmpFlag, 0);

    // R8: data without strobe ignored; flag rises only after the strobe edge
    busWrite(1, 16'h0080);
    resData = 12'hFFF; resChan = 5'd0;
    @(negedge clk);
    check(cmpFlag == 0, "R8 no strobe", cmpFlag, 0);
    resValid = 1'b1;
    #1;
    check(cmpFlag == 0, "R8 before edge", cmpFlag, 0);
    @(negedge clk);
    resValid = 1'b0;
    check(cmpFlag == 1, "R8 after edge", cmpFlag, 1);

    // R11: sticky through a non-matching result
    sendResult(12'h000, 5'd0);
    check(cmpFlag == 1, "R11 sticky", cmpFlag, 1);
    // R9: read status, write 1 has no effect, write 0 clears
    busRead(2, rd); check(rd == 16'h0001, "R9 status read", rd, 1);
    busWrite(2, 16'h0001);
    check(cmpFlag == 1, "R9 write one", cmpFlag, 1);
    busWrite(2, 16'h0000);
    check(cmpFlag == 0, "R9 clear", cmpFlag, 0);
    busRead(2, rd); check(rd == 16'h0000, "R9 status cleared", rd, 0);

    // R9: set wins over a clear in the same cycle
    regAddr = 2; regWrData = 16'h0000; regWrEn = 1'b1;
    resData = 12'h800; resChan = 5'd9; resValid = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; resValid = 1'b0;
    check(cmpFlag == 1, "R9 set wins", cmpFlag, 1);

    // R6: channel 31 boundary with filter on
    busWrite(1, 16'h00DF); // enable, mode 2 (filtered, >=), channel 31
    busWrite(2, 16'h0000);
    sendResult(12'hFFF, 5'd30);
    check(cmpFlag == 0, "R6 other channel", cmpFlag, 0);
    sendResult(12'h010, 5'd31);
    check(cmpFlag == 1, "R6 channel 31", cmpFlag, 1);

    finishRun();
  end
endmodule